// File: doc/BRIEF.md
# Home-Node Ownership Directory Controller

This block sits beside the home memory of a small set of shared blocks in a write-back multiprocessor. It records, for every block, whether no node caches it, one or more nodes hold read copies, or a single node owns it exclusively. Any node that wants to modify a block must first ask the home for ownership. The home then invalidates every other copy and treats its own memory copy as stale until an owner hands data back.

Nodes send requests, either read or ownership, on a request channel. Requests enter a small arrival-order queue and are served one at a time. The home talks to nodes through a single message channel with four kinds of message: invalidate, forward, grant and data. Nodes answer on a response channel. A response either acknowledges an invalidation or carries an owner's block data. When a non-owner reads an owned block, the home forwards the request to the owner, which supplies the requester directly. The owner's data also comes back to the home, which stores it and moves the block back to the shared state with both nodes recorded as sharers.

The controller is one state machine. From ST_IDLE it pops a request and moves to one of these states: ST_REPLY (immediate answer), ST_FWD (owned block read by another node) or ST_INV (ownership request with other holders). ST_INV issues one invalidation per cycle and then enters ST_WAIT. ST_FWD enters ST_WAIT after one cycle. ST_WAIT moves to ST_REPLY once every awaited response has arrived. ST_REPLY updates the directory entry, sends the final message if one is due, and returns to ST_IDLE.

Top module: `coherence_home`

## Requirements
- R1: After reset, every block is uncached and its home copy is zero. `msg_valid` is low and `req_ready` is high.
- R2: A read request (`req_excl`=0) for an uncached or shared block is answered with one DATA message (`msg_kind`=3) to the requester. The message carries the home copy, and the requester is added to the block's sharers.
- R3: Several nodes may hold read copies of one block at once. Each later read of a shared block gets DATA with no invalidations sent.
- R4: An ownership request (`req_excl`=1) for a shared block sends INV (`msg_kind`=0) to each sharer other than the requester. INVs go out one per cycle, lowest node index first, and never to the requester.
- R5: GRANT (`msg_kind`=2) goes to the requester only after a response has arrived from every node that was sent an INV. GRANT carries the home copy, and the block then becomes owned by the requester with no sharers.
- R6: An ownership request for an uncached block, or for a shared block whose only sharer is the requester, gets GRANT at once with no INV.
- R7: A read of an owned block by another node sends FWD (`msg_kind`=1) to the owner, with `msg_req` set to the reader. The home sends no DATA for that request.
- R8: The owner's data response to a FWD becomes the new home copy. The block becomes shared, with the former owner and the reader as its sharers.
- R9: An ownership request for a block owned by another node sends INV to the owner. The owner's data response is stored, and the following GRANT carries that data.
- R10: A request of either kind from the current owner of a block gets GRANT at once, and no message goes to any other node.
- R11: Requests are accepted while a transaction is in progress and are served in arrival order. `req_ready` drops only when the queue is full. Every message carries the requester in `msg_req`.
- R12: A response from a node the home is not waiting on is ignored. It does not complete the transaction and does not change the home copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request queue has room |
| req_node | input | $clog2(NODES) | Requesting node |
| req_blk | input | $clog2(BLOCKS) | Block index |
| req_excl | input | 1 | 1 = ownership request, 0 = read |
| msg_valid | output | 1 | Message to a node this cycle |
| msg_kind | output | 2 | 0 INV, 1 FWD, 2 GRANT, 3 DATA |
| msg_node | output | $clog2(NODES) | Destination node |
| msg_req | output | $clog2(NODES) | Node whose request is being served |
| msg_blk | output | $clog2(BLOCKS) | Block index |
| msg_data | output | DATA_W | Home copy (meaningful for GRANT and DATA) |
| resp_valid | input | 1 | Response from a node |
| resp_node | input | $clog2(NODES) | Responding node |
| resp_has_data | input | 1 | Response carries block data |
| resp_data | input | DATA_W | Owner's block data |

## Verification
The bound checker watches every cycle for four things: an invalidation or forward never addressed to the requester itself, GRANT and DATA always addressed to the requester, and no GRANT while an invalidated node has yet to respond. The properties the checker cannot see need the bench's scenarios. These are the contents of the directory (who ends up a sharer, which only a later invalidation round reveals), the values moved into the home copy, stray responses being ignored, and the arrival-order service of queued requests.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LINE_UNCACHED = 2'd0,
        LINE_SHARED   = 2'd1,
        LINE_OWNED    = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        MSG_INV   = 2'd0,
        MSG_FWD   = 2'd1,
        MSG_GRANT = 2'd2,
        MSG_DATA  = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INV,
        ST_FWD,
        ST_WAIT,
        ST_REPLY
    } home_state_e;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_READ,
        UPD_OWN,
        UPD_FWDREAD
    } upd_mode_e;

endpackage

// File: rtl/coh_req_fifo.sv
module coh_req_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         pop
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push, take;

    assign in_ready  = (cnt_q != CNT_W'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_data  = slot_q[rd_ptr_q];
    assign push      = in_valid && in_ready;
    assign take      = pop && out_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                slot_q[wr_ptr_q] <= in_data;
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (take) begin
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            if (push && !take)      cnt_q <= cnt_q + 1'b1;
            else if (take && !push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
    import coh_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BLOCKS)-1:0] rd_blk,
    output line_state_e               rd_state,
    output logic [NODES-1:0]          rd_sharers,
    output logic [$clog2(NODES)-1:0]  rd_owner,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      ent_we,
    input  logic [$clog2(BLOCKS)-1:0] ent_blk,
    input  line_state_e               ent_state,
    input  logic [NODES-1:0]          ent_sharers,
    input  logic [$clog2(NODES)-1:0]  ent_owner,
    input  logic                      dat_we,
    input  logic [$clog2(BLOCKS)-1:0] dat_blk,
    input  logic [DATA_W-1:0]         dat_data
);
    localparam int NID_W = $clog2(NODES);
    localparam int BID_W = $clog2(BLOCKS);

    line_state_e      st_q   [BLOCKS];
    logic [NODES-1:0] shr_q  [BLOCKS];
    logic [NID_W-1:0] own_q  [BLOCKS];
    logic [DATA_W-1:0] home_q [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[b]   <= LINE_UNCACHED;
                shr_q[b]  <= '0;
                own_q[b]  <= '0;
                home_q[b] <= '0;
            end else begin
                if (ent_we && ent_blk == BID_W'(b)) begin
                    st_q[b]  <= ent_state;
                    shr_q[b] <= ent_sharers;
                    own_q[b] <= ent_owner;
                end
                if (dat_we && dat_blk == BID_W'(b)) begin
                    home_q[b] <= dat_data;
                end
            end
        end
    end

    assign rd_state   = st_q[rd_blk];
    assign rd_sharers = shr_q[rd_blk];
    assign rd_owner   = own_q[rd_blk];
    assign rd_data    = home_q[rd_blk];
endmodule

// File: rtl/coh_home_fsm.sv
module coh_home_fsm
    import coh_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      head_valid,
    input  logic [$clog2(NODES)-1:0]  head_node,
    input  logic [$clog2(BLOCKS)-1:0] head_blk,
    input  logic                      head_excl,
    output logic                      pop,
    output logic [$clog2(BLOCKS)-1:0] rd_blk,
    input  line_state_e               rd_state,
    input  logic [NODES-1:0]          rd_sharers,
    input  logic [$clog2(NODES)-1:0]  rd_owner,
    input  logic [DATA_W-1:0]         rd_data,
    output logic                      ent_we,
    output logic [$clog2(BLOCKS)-1:0] ent_blk,
    output line_state_e               ent_state,
    output logic [NODES-1:0]          ent_sharers,
    output logic [$clog2(NODES)-1:0]  ent_owner,
    output logic                      dat_we,
    output logic [$clog2(BLOCKS)-1:0] dat_blk,
    output logic [DATA_W-1:0]         dat_data,
    input  logic                      resp_valid,
    input  logic [$clog2(NODES)-1:0]  resp_node,
    input  logic                      resp_has_data,
    input  logic [DATA_W-1:0]         resp_data,
    output logic                      msg_valid,
    output logic [1:0]                msg_kind,
    output logic [$clog2(NODES)-1:0]  msg_node,
    output logic [$clog2(NODES)-1:0]  msg_req,
    output logic [$clog2(BLOCKS)-1:0] msg_blk,
    output logic [DATA_W-1:0]         msg_data
);
    localparam int NID_W = $clog2(NODES);
    localparam int BID_W = $clog2(BLOCKS);

    home_state_e      state_q, state_d;
    logic [NID_W-1:0] cur_node_q, owner_q;
    logic [BID_W-1:0] cur_blk_q;
    logic [NODES-1:0] inv_todo_q, ack_wait_q;
    msg_kind_e        rep_kind_q;
    logic             rep_send_q;
    upd_mode_e        upd_q;

    // Decisions taken on the queue head in ST_IDLE
    logic [NODES-1:0] req_bit, own_bit, others, inv_mask;
    logic             is_owned, self_owned;
    // Next invalidation target
    logic [NID_W-1:0] pick_idx;
    logic [NODES-1:0] pick_bit;
    logic             awaiting, resp_hit;

    assign req_bit    = NODES'(1) << head_node;
    assign own_bit    = NODES'(1) << rd_owner;
    assign others     = rd_sharers & ~req_bit;
    assign is_owned   = (rd_state == LINE_OWNED);
    assign self_owned = is_owned && (rd_owner == head_node);
    assign inv_mask   = is_owned ? own_bit : others;

    always_comb begin
        pick_idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (inv_todo_q[i]) pick_idx = NID_W'(i);
        end
    end
    assign pick_bit = NODES'(1) << pick_idx;

    assign awaiting = (state_q == ST_INV) || (state_q == ST_FWD) || (state_q == ST_WAIT);
    assign resp_hit = awaiting && resp_valid && ack_wait_q[resp_node];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (head_valid) begin
                    if (self_owned)        state_d = ST_REPLY;
                    else if (!head_excl)   state_d = is_owned ? ST_FWD : ST_REPLY;
                    else                   state_d = (inv_mask != '0) ? ST_INV : ST_REPLY;
                end
            end
            ST_INV:   if ((inv_todo_q & ~pick_bit) == '0) state_d = ST_WAIT;
            ST_FWD:   state_d = ST_WAIT;
            ST_WAIT:  if (ack_wait_q == '0) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Transaction context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_node_q <= '0;
            cur_blk_q  <= '0;
            owner_q    <= '0;
            inv_todo_q <= '0;
            ack_wait_q <= '0;
            rep_kind_q <= MSG_DATA;
            rep_send_q <= 1'b0;
            upd_q      <= UPD_NONE;
        end else begin
            if (state_q == ST_IDLE && head_valid) begin
                cur_node_q <= head_node;
                cur_blk_q  <= head_blk;
                owner_q    <= rd_owner;
                inv_todo_q <= '0;
                ack_wait_q <= '0;
                if (self_owned) begin
                    rep_kind_q <= MSG_GRANT;
                    rep_send_q <= 1'b1;
                    upd_q      <= UPD_NONE;
                end else if (!head_excl) begin
                    if (is_owned) begin
                        rep_send_q <= 1'b0;
                        upd_q      <= UPD_FWDREAD;
                        ack_wait_q <= own_bit;
                    end else begin
                        rep_kind_q <= MSG_DATA;
                        rep_send_q <= 1'b1;
                        upd_q      <= UPD_READ;
                    end
                end else begin
                    rep_kind_q <= MSG_GRANT;
                    rep_send_q <= 1'b1;
                    upd_q      <= UPD_OWN;
                    inv_todo_q <= inv_mask;
                    ack_wait_q <= inv_mask;
                end
            end else begin
                if (state_q == ST_INV) inv_todo_q <= inv_todo_q & ~pick_bit;
                if (resp_hit) ack_wait_q[resp_node] <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        pop         = (state_q == ST_IDLE) && head_valid;
        rd_blk      = (state_q == ST_IDLE) ? head_blk : cur_blk_q;
        msg_valid   = 1'b0;
        msg_kind    = MSG_DATA;
        msg_node    = cur_node_q;
        msg_req     = cur_node_q;
        msg_blk     = cur_blk_q;
        msg_data    = rd_data;
        ent_we      = 1'b0;
        ent_blk     = cur_blk_q;
        ent_state   = rd_state;
        ent_sharers = rd_sharers;
        ent_owner   = rd_owner;
        dat_we      = resp_hit && resp_has_data;
        dat_blk     = cur_blk_q;
        dat_data    = resp_data;
        unique case (state_q)
            ST_INV: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_INV;
                msg_node  = pick_idx;
            end
            ST_FWD: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_FWD;
                msg_node  = owner_q;
            end
            ST_REPLY: begin
                msg_valid = rep_send_q;
                msg_kind  = rep_kind_q;
                ent_we    = (upd_q != UPD_NONE);
                unique case (upd_q)
                    UPD_READ: begin
                        ent_state   = LINE_SHARED;
                        ent_sharers = rd_sharers | (NODES'(1) << cur_node_q);
                    end
                    UPD_OWN: begin
                        ent_state   = LINE_OWNED;
                        ent_sharers = '0;
                        ent_owner   = cur_node_q;
                    end
                    UPD_FWDREAD: begin
                        ent_state   = LINE_SHARED;
                        ent_sharers = (NODES'(1) << owner_q) | (NODES'(1) << cur_node_q);
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/coherence_home.sv
module coherence_home
    import coh_pkg::*;
#(
    parameter int NODES   = 4,
    parameter int BLOCKS  = 4,
    parameter int DATA_W  = 16,
    parameter int Q_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [$clog2(NODES)-1:0]  req_node,
    input  logic [$clog2(BLOCKS)-1:0] req_blk,
    input  logic                      req_excl,
    output logic                      msg_valid,
    output logic [1:0]                msg_kind,
    output logic [$clog2(NODES)-1:0]  msg_node,
    output logic [$clog2(NODES)-1:0]  msg_req,
    output logic [$clog2(BLOCKS)-1:0] msg_blk,
    output logic [DATA_W-1:0]         msg_data,
    input  logic                      resp_valid,
    input  logic [$clog2(NODES)-1:0]  resp_node,
    input  logic                      resp_has_data,
    input  logic [DATA_W-1:0]         resp_data
);
    localparam int NID_W = $clog2(NODES);
    localparam int BID_W = $clog2(BLOCKS);
    localparam int REQ_W = NID_W + BID_W + 1;

    logic             head_valid, pop;
    logic [REQ_W-1:0] head;
    logic [BID_W-1:0] rd_blk, ent_blk, dat_blk;
    line_state_e      rd_state, ent_state;
    logic [NODES-1:0] rd_sharers, ent_sharers;
    logic [NID_W-1:0] rd_owner, ent_owner;
    logic [DATA_W-1:0] rd_data, dat_data;
    logic             ent_we, dat_we;

    coh_req_fifo #(.W(REQ_W), .DEPTH(Q_DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_data   ({req_node, req_blk, req_excl}),
        .in_ready  (req_ready),
        .out_valid (head_valid),
        .out_data  (head),
        .pop       (pop)
    );

    coh_dir_table #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_blk      (rd_blk),
        .rd_state    (rd_state),
        .rd_sharers  (rd_sharers),
        .rd_owner    (rd_owner),
        .rd_data     (rd_data),
        .ent_we      (ent_we),
        .ent_blk     (ent_blk),
        .ent_state   (ent_state),
        .ent_sharers (ent_sharers),
        .ent_owner   (ent_owner),
        .dat_we      (dat_we),
        .dat_blk     (dat_blk),
        .dat_data    (dat_data)
    );

    coh_home_fsm #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_valid    (head_valid),
        .head_node     (head[REQ_W-1 -: NID_W]),
        .head_blk      (head[BID_W:1]),
        .head_excl     (head[0]),
        .pop           (pop),
        .rd_blk        (rd_blk),
        .rd_state      (rd_state),
        .rd_sharers    (rd_sharers),
        .rd_owner      (rd_owner),
        .rd_data       (rd_data),
        .ent_we        (ent_we),
        .ent_blk       (ent_blk),
        .ent_state     (ent_state),
        .ent_sharers   (ent_sharers),
        .ent_owner     (ent_owner),
        .dat_we        (dat_we),
        .dat_blk       (dat_blk),
        .dat_data      (dat_data),
        .resp_valid    (resp_valid),
        .resp_node     (resp_node),
        .resp_has_data (resp_has_data),
        .resp_data     (resp_data),
        .msg_valid     (msg_valid),
        .msg_kind      (msg_kind),
        .msg_node      (msg_node),
        .msg_req       (msg_req),
        .msg_blk       (msg_blk),
        .msg_data      (msg_data)
    );
endmodule

// File: rtl/coh_home_checks.sv
module coh_home_checks #(
    parameter int NODES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     msg_valid,
    input logic [1:0]               msg_kind,
    input logic [$clog2(NODES)-1:0] msg_node,
    input logic [$clog2(NODES)-1:0] msg_req,
    input logic                     resp_valid,
    input logic [$clog2(NODES)-1:0] resp_node
);
    // Nodes sent an INV that have not yet responded, seen only from the ports
    logic [NODES-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NODES; i++) begin
                if (msg_valid && msg_kind == 2'd0 && msg_node == $clog2(NODES)'(i))
                    pend_q[i] <= 1'b1;
                else if (resp_valid && resp_node == $clog2(NODES)'(i))
                    pend_q[i] <= 1'b0;
            end
        end
    end

    assert_inv_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd0) |-> (msg_node != msg_req));

    assert_grant_after_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd2) |-> (pend_q == '0));

    assert_fwd_to_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd1) |-> (msg_node != msg_req));

    assert_reply_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind[1]) |-> (msg_node == msg_req));
endmodule

bind coherence_home coh_home_checks #(.NODES(NODES)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_kind   (msg_kind),
    .msg_node   (msg_node),
    .msg_req    (msg_req),
    .resp_valid (resp_valid),
    .resp_node  (resp_node)
);

// File: tb/coherence_home_test.sv
`timescale 1ns/1ps
module coherence_home_test;
    localparam int NODES = 4, BLOCKS = 4, DATA_W = 16;
    localparam logic [1:0] K_INV = 2'd0, K_FWD = 2'd1, K_GRANT = 2'd2, K_DATA = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_excl = 1'b0;
    logic [1:0] req_node = '0, req_blk = '0;
    logic req_ready, msg_valid;
    logic [1:0] msg_kind, msg_node, msg_req, msg_blk;
    logic [DATA_W-1:0] msg_data;
    logic resp_valid = 1'b0, resp_has_data = 1'b0;
    logic [1:0] resp_node = '0;
    logic [DATA_W-1:0] resp_data = '0;

    int checks = 0, errors = 0;

    typedef struct {
        logic [1:0] kind, node, req, blk;
        logic [DATA_W-1:0] data;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t e;

    always #10 clk = ~clk;

    coherence_home #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
        .req_blk(req_blk), .req_excl(req_excl),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
        .msg_req(msg_req), .msg_blk(msg_blk), .msg_data(msg_data),
        .resp_valid(resp_valid), .resp_node(resp_node),
        .resp_has_data(resp_has_data), .resp_data(resp_data)
    );

    // Monitor: pops the scoreboard whenever the design emits a message
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected msg kind=%0d node=%0d req=%0d blk=%0d data=%h (expected none)",
                         msg_kind, msg_node, msg_req, msg_blk, msg_data);
            end else begin
                e = exp_q.pop_front();
                if (msg_kind !== e.kind || msg_node !== e.node || msg_req !== e.req ||
                    msg_blk !== e.blk || (e.kind[1] && msg_data !== e.data)) begin
                    errors++;
                    $display("FAIL %s actual kind=%0d node=%0d req=%0d blk=%0d data=%h expected kind=%0d node=%0d req=%0d blk=%0d data=%h",
                             e.tag, msg_kind, msg_node, msg_req, msg_blk, msg_data,
                             e.kind, e.node, e.req, e.blk, e.data);
                end
            end
        end
    end

    task automatic expect_msg(input logic [1:0] k, input logic [1:0] n, input logic [1:0] r,
                              input logic [1:0] b, input logic [DATA_W-1:0] d, input string tag);
        exp_t x;
        x.kind = k; x.node = n; x.req = r; x.blk = b; x.data = d; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // Called at a falling edge; returns at a falling edge
    task automatic send_req(input logic [1:0] n, input logic [1:0] b, input logic x);
        req_valid = 1'b1; req_node = n; req_blk = b; req_excl = x;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic respond(input logic [1:0] n, input logic hd, input logic [DATA_W-1:0] d);
        resp_valid = 1'b1; resp_node = n; resp_has_data = hd; resp_data = d;
        @(negedge clk);
        resp_valid = 1'b0; resp_has_data = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL %s missing msg: actual none expected kind=%0d node=%0d",
                     exp_q[0].tag, exp_q[0].kind, exp_q[0].node);
            exp_q.delete();
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (req_ready !== 1'b1 || msg_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 ready=%b valid=%b expected ready=1 valid=0", req_ready, msg_valid);
        end

        // R2: read of an uncached block, home copy is zero after reset (R1)
        expect_msg(K_DATA, 0, 0, 0, 16'h0000, "R2 read uncached");
        send_req(0, 0, 1'b0);
        drain();

        // R3 / R11: two more readers queued back to back
        expect_msg(K_DATA, 1, 1, 0, 16'h0000, "R3 second reader");
        expect_msg(K_DATA, 2, 2, 0, 16'h0000, "R3 third reader");
        send_req(1, 0, 1'b0);
        send_req(2, 0, 1'b0);
        drain();

        // R4: ownership by node1 invalidates 0 then 2
        expect_msg(K_INV, 0, 1, 0, 16'h0, "R4 inv node0");
        expect_msg(K_INV, 2, 1, 0, 16'h0, "R4 inv node2");
        send_req(1, 0, 1'b1);
        drain();
        // R12: stray response from node3 must not complete the transaction
        respond(3, 1'b1, 16'hDEAD);
        repeat (4) @(negedge clk);
        // R5: grant only after both acks
        respond(2, 1'b0, 16'h0);
        repeat (3) @(negedge clk);
        expect_msg(K_GRANT, 1, 1, 0, 16'h0000, "R5 grant after all acks / R12 home copy kept");
        respond(0, 1'b0, 16'h0);
        drain();

        // R10: owner asks again
        expect_msg(K_GRANT, 1, 1, 0, 16'h0000, "R10 owner re-request");
        send_req(1, 0, 1'b1);
        drain();

        // R7: read of owned block forwarded to owner
        expect_msg(K_FWD, 1, 3, 0, 16'h0, "R7 forward to owner");
        send_req(3, 0, 1'b0);
        drain();
        respond(1, 1'b1, 16'hBEEF);
        repeat (2) @(negedge clk);
        // R8: home copy now holds owner data
        expect_msg(K_DATA, 0, 0, 0, 16'hBEEF, "R8 home copy updated");
        send_req(0, 0, 1'b0);
        drain();
        // R8: sharers are owner(1), reader(3) and node0
        expect_msg(K_INV, 0, 2, 0, 16'h0, "R8 sharer 0");
        expect_msg(K_INV, 1, 2, 0, 16'h0, "R8 former owner is sharer");
        expect_msg(K_INV, 3, 2, 0, 16'h0, "R8 reader is sharer");
        send_req(2, 0, 1'b1);
        drain();
        respond(0, 1'b0, 16'h0);
        respond(1, 1'b0, 16'h0);
        expect_msg(K_GRANT, 2, 2, 0, 16'hBEEF, "R5 grant carries home copy");
        respond(3, 1'b0, 16'h0);
        drain();

        // R6: uncached ownership, then R9 transfer between owners
        expect_msg(K_GRANT, 0, 0, 1, 16'h0000, "R6 grant uncached");
        send_req(0, 1, 1'b1);
        drain();
        expect_msg(K_INV, 0, 3, 1, 16'h0, "R9 inv to owner");
        send_req(3, 1, 1'b1);
        drain();
        expect_msg(K_GRANT, 3, 3, 1, 16'h1234, "R9 grant with owner data");
        respond(0, 1'b1, 16'h1234);
        drain();

        // R6: requester is the only sharer
        expect_msg(K_DATA, 2, 2, 2, 16'h0000, "R2 read blk2");
        expect_msg(K_GRANT, 2, 2, 2, 16'h0000, "R6 sole sharer upgrade");
        send_req(2, 2, 1'b0);
        send_req(2, 2, 1'b1);
        drain();

        // R11: three queued requests served in order across a forward
        expect_msg(K_GRANT, 1, 1, 3, 16'h0000, "R11 first in order");
        expect_msg(K_FWD, 1, 0, 3, 16'h0, "R11 second in order");
        expect_msg(K_GRANT, 2, 2, 2, 16'h0000, "R11 third in order / R10");
        send_req(1, 3, 1'b1);
        send_req(0, 3, 1'b0);
        send_req(2, 2, 1'b0);
        for (int n = 0; n < 100 && exp_q.size() > 1; n++) @(negedge clk);
        // R12: stray data from node2 while waiting on owner 1
        respond(2, 1'b1, 16'hDEAD);
        repeat (3) @(negedge clk);
        respond(1, 1'b1, 16'h0055);
        drain();
        expect_msg(K_DATA, 3, 3, 3, 16'h0055, "R12 stray data ignored / R8");
        send_req(3, 3, 1'b0);
        drain();

        summary();
        $finish;
    end
endmodule